// File: doc/BRIEF.md
# I2C Target Front End for a Three-Register Space

This block is the serial side of a small control peripheral. It watches an I2C bus (SCL and SDA) from a free-running system clock. It brings both lines through a two-flop synchroniser and finds SCL edges, START, repeated START and STOP in the system clock domain. The 7-bit device address is a fixed five-bit prefix `01010` followed by two strap pins. A neighbouring register block holds the storage. This front end gives that block one-cycle read and write strobes and accepts read data one clock after a read strobe.

A write transaction is START, the address byte with R/W = 0, a register index byte and exactly one data byte. The write reaches the register block only when STOP arrives. A read transaction first sets the register index with a write-style prefix. A repeated START then follows with R/W = 1, and the target returns bytes for as long as the master acknowledges them. The index advances after each byte and wraps from the last register back to 0. SDA is never driven high: the block only asserts an active-low output enable that pulls the line low. A power-up qualifier input holds the interface idle until the host system reports that start-up is complete.

Top module: `i2c_regtgt`

## Requirements
- R1: After reset, `sda_oe_n` is 1 (SDA released), and `wr_strobe` and `rd_strobe` are 0.
- R2: The address byte is received MSB first. Its bits 7..3 must be `01010`, bit 2 must equal `strap[1]`, bit 1 must equal `strap[0]`, and bit 0 is R/W (1 = read, 0 = write). A matching byte is acknowledged by pulling SDA low during the ninth SCL clock.
- R3: In a write, a register index byte below NUM_REGS (3) is acknowledged. The one data byte that follows it is also acknowledged.
- R4: A write takes effect only at STOP. `wr_strobe` pulses for one clock after STOP is detected, carrying `wr_addr` equal to the index and `wr_data` equal to the data byte. No write strobe occurs before STOP.
- R5: After a repeated START and a matching address byte with R/W = 1, the target sends the indexed register MSB first. SDA changes are made only while SCL is low.
- R6: During a read, each master ACK advances the index by one, with wrap from 2 to 0, and the next register is sent. A master NACK ends the output.
- R7: An address byte that does not match gets no ACK. The rest of the transaction is ignored: no ACK on any later byte and no write at the following STOP.
- R8: While `boot_done` is 0, START is ignored, SDA stays released and no strobe is issued.
- R9: A register index byte of NUM_REGS (3) or above gets no ACK. The rest of the transaction is ignored and no write follows.
- R10: Any byte after the first data byte of a write gets no ACK. The first data byte is still written at STOP.
- R11: A repeated START that arrives before STOP discards a pending write.
- R12: `rd_strobe` is a single-clock pulse with `rd_addr` below NUM_REGS. `rd_data` is taken one clock after the strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_done | input | 1 | High once power-up is complete; START is ignored while low |
| strap | input | 2 | Strap pins forming address bits 2 and 1 |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_n | output | 1 | Active-low pull-down enable for SDA (0 = drive low) |
| rd_addr | output | 2 | Register index for reads |
| rd_strobe | output | 1 | One-clock read request |
| rd_data | input | 8 | Read data, valid one clock after `rd_strobe` |
| wr_strobe | output | 1 | One-clock write commit, issued after STOP |
| wr_addr | output | 2 | Register index for the write |
| wr_data | output | 8 | Data byte for the write |

## Verification
A wrong bit counter or a wrong state shows up as a missing or misplaced ACK. It can be seen at the ninth clock of the very byte that went wrong, because the master samples SDA in the middle of each high phase. A pointer that fails to advance or wrap shows up as the wrong value in the second or third byte of a read. A write that commits too early or survives a repeated START shows up as a write strobe the register model records, or the absence of one, within a few clocks after STOP. Mismatched addresses and indices are checked by the lack of an ACK and by an unchanged write count after the transaction.

// File: rtl/i2c_regtgt_pkg.sv
package i2c_regtgt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ID,
    ST_REG,
    ST_WDATA,
    ST_WDONE,
    ST_RDATA,
    ST_RACK,
    ST_SKIP
  } tgt_state_e;
endpackage

// File: rtl/i2c_regtgt_sync.sv
module i2c_regtgt_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '1;
    end else begin
      for (int i = STAGES - 1; i > 0; i--) stg[i] <= stg[i-1];
      stg[0] <= din;
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/i2c_regtgt_cond.sv
module i2c_regtgt_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  // Data line moving while the clock stays high marks a bus condition
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_regtgt_engine.sv
module i2c_regtgt_engine
  import i2c_regtgt_pkg::*;
#(
  parameter logic [4:0] ADDR_PREFIX = 5'b01010,
  parameter int         NUM_REGS    = 3,
  parameter int         AW          = 2,
  parameter int         DW          = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          boot_done,
  input  logic [1:0]    strap,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [DW-1:0] rd_data,
  output logic          sda_oe_n,
  output logic [AW-1:0] rd_addr,
  output logic          rd_strobe,
  output logic          wr_strobe,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  localparam int           CW       = $clog2(DW + 1);
  localparam logic [CW-1:0] BITS_FULL = CW'(DW);
  localparam logic [AW-1:0] PTR_LAST  = AW'(NUM_REGS - 1);
  localparam logic [DW-1:0] NUM_B     = DW'(NUM_REGS);

  tgt_state_e    state, nxt;
  logic [CW-1:0] bitcnt;
  logic          ack_ph;
  logic [DW-1:0] rx_sh, tx_sh, wdat;
  logic [AW-1:0] ptr;
  logic          pend, fetch_go, rd_str_r, load_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      nxt       <= ST_IDLE;
      bitcnt    <= '0;
      ack_ph    <= 1'b0;
      rx_sh     <= '0;
      tx_sh     <= '1;
      wdat      <= '0;
      ptr       <= '0;
      pend      <= 1'b0;
      fetch_go  <= 1'b0;
      rd_str_r  <= 1'b0;
      load_q    <= 1'b0;
      sda_oe_n  <= 1'b1;
      wr_strobe <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      fetch_go  <= 1'b0;
      wr_strobe <= 1'b0;
      rd_str_r  <= fetch_go;
      load_q    <= rd_str_r;
      if (load_q) tx_sh <= rd_data;

      if (!boot_done) begin
        state    <= ST_IDLE;
        ack_ph   <= 1'b0;
        pend     <= 1'b0;
        sda_oe_n <= 1'b1;
      end else if (stop_det) begin
        if (pend) begin
          wr_strobe <= 1'b1;
          wr_addr   <= ptr;
          wr_data   <= wdat;
        end
        pend     <= 1'b0;
        state    <= ST_IDLE;
        ack_ph   <= 1'b0;
        sda_oe_n <= 1'b1;
      end else if (start_det) begin
        pend     <= 1'b0;
        state    <= ST_ID;
        bitcnt   <= '0;
        ack_ph   <= 1'b0;
        sda_oe_n <= 1'b1;
      end else begin
        unique case (state)
          ST_ID, ST_REG, ST_WDATA: begin
            if (ack_ph) begin
              if (scl_fall) begin
                ack_ph <= 1'b0;
                bitcnt <= '0;
                state  <= nxt;
                // entering a read puts the first data bit on the line at once
                sda_oe_n <= (nxt == ST_RDATA) ? tx_sh[DW-1] : 1'b1;
              end
            end else begin
              if (scl_rise && bitcnt != BITS_FULL) begin
                rx_sh  <= {rx_sh[DW-2:0], sda_s};
                bitcnt <= bitcnt + 1'b1;
              end
              if (scl_fall && bitcnt == BITS_FULL) begin
                if (state == ST_ID) begin
                  if (rx_sh[7:1] == {ADDR_PREFIX, strap}) begin
                    ack_ph   <= 1'b1;
                    sda_oe_n <= 1'b0;
                    if (rx_sh[0]) begin
                      nxt      <= ST_RDATA;
                      fetch_go <= 1'b1;
                    end else begin
                      nxt <= ST_REG;
                    end
                  end else begin
                    state <= ST_SKIP;
                  end
                end else if (state == ST_REG) begin
                  if (rx_sh < NUM_B) begin
                    ptr      <= rx_sh[AW-1:0];
                    ack_ph   <= 1'b1;
                    sda_oe_n <= 1'b0;
                    nxt      <= ST_WDATA;
                  end else begin
                    state <= ST_SKIP;
                  end
                end else begin
                  wdat     <= rx_sh;
                  pend     <= 1'b1;
                  ack_ph   <= 1'b1;
                  sda_oe_n <= 1'b0;
                  nxt      <= ST_WDONE;
                end
              end
            end
          end
          ST_RDATA: begin
            if (scl_rise) bitcnt <= bitcnt + 1'b1;
            if (scl_fall) begin
              if (bitcnt == BITS_FULL) begin
                sda_oe_n <= 1'b1;
                state    <= ST_RACK;
                bitcnt   <= '0;
              end else if (bitcnt != '0) begin
                tx_sh    <= {tx_sh[DW-2:0], 1'b1};
                sda_oe_n <= tx_sh[DW-2];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              if (!sda_s) begin
                ptr      <= (ptr == PTR_LAST) ? '0 : ptr + 1'b1;
                fetch_go <= 1'b1;
                bitcnt   <= CW'(1);
              end else begin
                state <= ST_SKIP;
              end
            end
            if (scl_fall && bitcnt == CW'(1)) begin
              state    <= ST_RDATA;
              bitcnt   <= '0;
              sda_oe_n <= tx_sh[DW-1];
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign rd_addr   = ptr;
  assign rd_strobe = rd_str_r;
endmodule

// File: rtl/i2c_regtgt.sv
module i2c_regtgt #(
  parameter logic [4:0] ADDR_PREFIX = 5'b01010,
  parameter int         NUM_REGS    = 3,
  parameter int         AW          = $clog2(NUM_REGS),
  parameter int         DW          = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          boot_done,
  input  logic [1:0]    strap,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe_n,
  output logic [AW-1:0] rd_addr,
  output logic          rd_strobe,
  input  logic [DW-1:0] rd_data,
  output logic          wr_strobe,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start_det, stop_det;

  i2c_regtgt_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din ({scl_i, sda_i}),
    .dout({scl_s, sda_s})
  );

  i2c_regtgt_cond u_cond (
    .clk      (clk),
    .rst      (rst),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  i2c_regtgt_engine #(
    .ADDR_PREFIX(ADDR_PREFIX),
    .NUM_REGS   (NUM_REGS),
    .AW         (AW),
    .DW         (DW)
  ) u_eng (
    .clk      (clk),
    .rst      (rst),
    .boot_done(boot_done),
    .strap    (strap),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det),
    .rd_data  (rd_data),
    .sda_oe_n (sda_oe_n),
    .rd_addr  (rd_addr),
    .rd_strobe(rd_strobe),
    .wr_strobe(wr_strobe),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data)
  );
endmodule

// File: rtl/i2c_regtgt_chk.sv
module i2c_regtgt_chk #(
  parameter int NUM_REGS = 3,
  parameter int AW       = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          boot_done,
  input logic          scl_s,
  input logic          stop_det,
  input logic          sda_oe_n,
  input logic          rd_strobe,
  input logic [AW-1:0] rd_addr,
  input logic          wr_strobe
);
  a_r4_commit_at_stop: assert property (@(posedge clk) disable iff (rst)
    wr_strobe |-> $past(stop_det));

  a_r8_boot_released: assert property (@(posedge clk) disable iff (rst)
    !boot_done |=> sda_oe_n);

  a_r5_change_scl_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe_n) |-> !scl_s);

  a_r12_rd_pulse: assert property (@(posedge clk) disable iff (rst)
    rd_strobe |=> !rd_strobe);

  a_r12_rd_range: assert property (@(posedge clk) disable iff (rst)
    rd_strobe |-> (int'(rd_addr) < NUM_REGS));

  a_r4_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(wr_strobe && rd_strobe));
endmodule

bind i2c_regtgt i2c_regtgt_chk #(.NUM_REGS(NUM_REGS), .AW(AW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .boot_done(boot_done),
  .scl_s    (scl_s),
  .stop_det (stop_det),
  .sda_oe_n (sda_oe_n),
  .rd_strobe(rd_strobe),
  .rd_addr  (rd_addr),
  .wr_strobe(wr_strobe)
);

// File: tb/i2c_regtgt_tb.sv
`timescale 1ns/1ps
module i2c_regtgt_tb;
  localparam int Q = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       boot_done = 1'b1;
  logic [1:0] strap = 2'b01;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_oe_n;
  logic [1:0] rd_addr;
  logic       rd_strobe;
  logic [7:0] rd_data;
  logic       wr_strobe;
  logic [1:0] wr_addr;
  logic [7:0] wr_data;
  wire        sda_bus = sda_m & sda_oe_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] regs [3];
  int         wr_cnt;
  logic [1:0] last_a;
  logic [7:0] last_d;

  always #2 clk = ~clk;

  i2c_regtgt u_dut (
    .clk(clk), .rst(rst), .boot_done(boot_done), .strap(strap),
    .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_n(sda_oe_n),
    .rd_addr(rd_addr), .rd_strobe(rd_strobe), .rd_data(rd_data),
    .wr_strobe(wr_strobe), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  // register block model
  always_ff @(posedge clk) begin
    if (rst) begin
      regs    <= '{8'h11, 8'h22, 8'h33};
      rd_data <= 8'h00;
      wr_cnt  <= 0;
      last_a  <= 2'd0;
      last_d  <= 8'h00;
    end else begin
      if (rd_strobe) rd_data <= regs[rd_addr];
      if (wr_strobe) begin
        regs[wr_addr] <= wr_data;
        wr_cnt <= wr_cnt + 1;
        last_a <= wr_addr;
        last_d <= wr_data;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qwait();
    scl_m = 1'b1; qwait();
    sda_m = 1'b0; qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qwait();
    scl_m = 1'b1; qwait();
    sda_m = 1'b1; qwait();
  endtask

  task automatic clock_bit(input logic b, output logic s);
    sda_m = b; qwait();
    scl_m = 1'b1; qwait();
    s = sda_bus; qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic send_byte(input logic [7:0] d, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) clock_bit(d[i], s);
    clock_bit(1'b1, s);
    acked = ~s;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] d);
    logic s;
    d = 8'h00;
    for (int i = 0; i < 8; i++) begin
      clock_bit(1'b1, s);
      d = {d[6:0], s};
    end
    clock_bit(~give_ack, s);
  endtask

  function automatic logic [7:0] id_byte(input logic [1:0] st, input logic rw);
    return {5'b01010, st, rw};
  endfunction

  task automatic t_reset();
    chk("R1 sda released after reset", sda_oe_n, 1);
    chk("R1 no write strobe after reset", wr_strobe, 0);
    chk("R1 no read strobe after reset", rd_strobe, 0);
  endtask

  task automatic t_write();
    logic a; int c0;
    c0 = wr_cnt;
    bus_start();
    send_byte(id_byte(2'b01, 1'b0), a); chk("R2 write id ack", a, 1);
    send_byte(8'h01, a); chk("R3 index ack", a, 1);
    send_byte(8'hA5, a); chk("R3 data ack", a, 1);
    chk("R4 no write before stop", wr_cnt, c0);
    bus_stop(); repeat (8) @(negedge clk);
    chk("R4 one write at stop", wr_cnt, c0 + 1);
    chk("R4 write index", last_a, 1);
    chk("R4 write data", last_d, 8'hA5);
  endtask

  task automatic t_read_single();
    logic a; logic [7:0] d;
    bus_start();
    send_byte(id_byte(2'b01, 1'b0), a);
    send_byte(8'h02, a);
    bus_start();
    send_byte(id_byte(2'b01, 1'b1), a); chk("R2 read id ack", a, 1);
    recv_byte(1'b0, d); chk("R5 R12 single read data", d, 8'h33);
    bus_stop(); repeat (8) @(negedge clk);
  endtask

  task automatic t_read_burst();
    logic a; logic [7:0] d;
    bus_start();
    send_byte(id_byte(2'b01, 1'b0), a);
    send_byte(8'h01, a);
    bus_start();
    send_byte(id_byte(2'b01, 1'b1), a);
    recv_byte(1'b1, d); chk("R6 burst byte0 idx1", d, 8'hA5);
    recv_byte(1'b1, d); chk("R6 burst byte1 idx2", d, 8'h33);
    recv_byte(1'b0, d); chk("R6 burst wrap idx0", d, 8'h11);
    chk("R6 sda released after nack", sda_oe_n, 1);
    bus_stop(); repeat (8) @(negedge clk);
  endtask

  task automatic t_bad_id();
    logic a; int c0;
    c0 = wr_cnt;
    bus_start();
    send_byte(id_byte(2'b11, 1'b0), a); chk("R7 wrong id no ack", a, 0);
    send_byte(8'h01, a); chk("R7 later byte no ack", a, 0);
    bus_stop(); repeat (8) @(negedge clk);
    chk("R7 no write", wr_cnt, c0);
  endtask

  task automatic t_bad_index();
    logic a; int c0;
    c0 = wr_cnt;
    bus_start();
    send_byte(id_byte(2'b01, 1'b0), a);
    send_byte(8'h03, a); chk("R9 index 3 no ack", a, 0);
    send_byte(8'h77, a); chk("R9 data after bad index no ack", a, 0);
    bus_stop(); repeat (8) @(negedge clk);
    chk("R9 no write", wr_cnt, c0);
  endtask

  task automatic t_extra_byte();
    logic a; int c0;
    c0 = wr_cnt;
    bus_start();
    send_byte(id_byte(2'b01, 1'b0), a);
    send_byte(8'h00, a);
    send_byte(8'h5A, a); chk("R10 first data ack", a, 1);
    send_byte(8'h66, a); chk("R10 second data no ack", a, 0);
    bus_stop(); repeat (8) @(negedge clk);
    chk("R10 one write", wr_cnt, c0 + 1);
    chk("R10 first byte kept", last_d, 8'h5A);
    chk("R10 index", last_a, 0);
  endtask

  task automatic t_rstart_discard();
    logic a; logic [7:0] d; int c0;
    c0 = wr_cnt;
    bus_start();
    send_byte(id_byte(2'b01, 1'b0), a);
    send_byte(8'h02, a);
    send_byte(8'hEE, a);
    bus_start();
    send_byte(id_byte(2'b01, 1'b1), a);
    recv_byte(1'b0, d); chk("R11 register unchanged", d, 8'h33);
    bus_stop(); repeat (8) @(negedge clk);
    chk("R11 no write", wr_cnt, c0);
  endtask

  task automatic t_boot();
    logic a; int c0;
    c0 = wr_cnt;
    boot_done = 1'b0;
    bus_start();
    send_byte(id_byte(2'b01, 1'b0), a); chk("R8 no ack while booting", a, 0);
    send_byte(8'h01, a);
    send_byte(8'h44, a);
    bus_stop(); repeat (8) @(negedge clk);
    chk("R8 no write while booting", wr_cnt, c0);
    boot_done = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_strap();
    logic a; int c0;
    strap = 2'b10;
    repeat (4) @(negedge clk);
    c0 = wr_cnt;
    bus_start();
    send_byte(id_byte(2'b10, 1'b0), a); chk("R2 new strap ack", a, 1);
    send_byte(8'h00, a);
    send_byte(8'hC3, a);
    bus_stop(); repeat (8) @(negedge clk);
    chk("R4 strap write data", last_d, 8'hC3);
    chk("R4 strap write count", wr_cnt, c0 + 1);
    bus_start();
    send_byte(id_byte(2'b01, 1'b0), a); chk("R2 old strap no ack", a, 0);
    bus_stop(); repeat (8) @(negedge clk);
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    t_reset();
    t_write();
    t_read_single();
    t_read_burst();
    t_bad_id();
    t_bad_index();
    t_extra_byte();
    t_rstart_discard();
    t_boot();
    t_strap();
    done = 1;
    finish_sim();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_sim();
    end
  end
endmodule